// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit integer processor core that completes one instruction on every clock edge. In a single cycle it fetches the instruction word, decodes it, reads two source registers, runs the ALU, accesses data memory and writes the result back. The instruction set is a reduced RV32I subset:

- register-register arithmetic, logic, shift and compare operations;
- immediate-form arithmetic and compare operations;
- signed byte and halfword loads, and word loads;
- byte, halfword and word stores;
- six conditional branches;
- the two upper-immediate forms;
- the two jump-and-link forms.

The core is used with two external memories that answer combinationally within the same cycle. The instruction memory is word-addressed. The data memory is also word-addressed and has one write-enable lane per byte. A debug read port exposes any register so that a testbench can inspect architectural state. Any encoding outside the supported list behaves as a no-op that only advances the program counter.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the PC becomes 0 and all 32 registers become zero.
- R2: Register-register operations compute their results: add, subtract, and, or, xor, shift left, logical shift right, arithmetic shift right, signed set-less-than and unsigned set-less-than. Shift amounts come from the low 5 bits of rs2.
- R3: Immediate operations compute their results with the sign-extended 12-bit immediate: add, and, or, xor, signed set-less-than and unsigned set-less-than.
- R4: LUI writes imm20<<12 to rd. AUIPC writes PC + (imm20<<12) to rd.
- R5: Loads read the word at byte address rs1+imm. LW returns the whole word. LB and LH return byte `addr[1:0]` or halfword `addr[1]`, sign-extended. Byte k occupies bits 8k+7:8k. `dmem_rd_en` is high only while a load executes and never together with `dmem_wr_en`.
- R6: Stores raise `dmem_wr_en`. SW sets `dmem_be`=1111. SH sets 0011 or 1100, chosen by `addr[1]`. SB sets 0001<<`addr[1:0]`. The low byte or halfword of rs2 is replicated across `dmem_wdata`.
- R7: BEQ, BNE, BLT, BGE, BLTU and BGEU compare rs1 with rs2, signed or unsigned as named. A taken branch sets PC to PC + the B-immediate. A branch that is not taken sets PC to PC+4.
- R8: JAL writes PC+4 to rd and jumps to PC + the J-immediate. JALR writes PC+4 to rd and jumps to (rs1+imm) with bit 0 cleared.
- R9: Register x0 always reads as zero, and writes to it are discarded.
- R10: An instruction whose opcode is not one of 0x33, 0x13, 0x03, 0x23, 0x63, 0x37, 0x17, 0x6F or 0x67 writes no register and no memory, and advances the PC by 4.
- R11: After reset is released the PC changes on every clock edge: it advances by 4 unless a jump or a taken branch redirects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | IMEM_AW (8) | Instruction word address, PC[IMEM_AW+1:2] |
| imem_rdata | input | 32 | Instruction word, combinational reply |
| dmem_addr | output | DMEM_AW (8) | Data word address, effective address [DMEM_AW+1:2] |
| dmem_rd_en | output | 1 | Load in progress |
| dmem_wr_en | output | 1 | Store in progress, written at the clock edge |
| dmem_be | output | 4 | Byte lane enables for the store |
| dmem_wdata | output | 32 | Store data, replicated across lanes |
| dmem_rdata | input | 32 | Data word, combinational reply |
| pc_o | output | 32 | Current program counter |
| dbg_raddr | input | 5 | Debug register index |
| dbg_rdata | output | 32 | Debug register value |

## Verification
Every instruction retires in the cycle it is fetched, so a wrong decode or a wrong next-PC choice shows at `pc_o` one clock edge later. The bench therefore compares the PC against an expected trace on every cycle, and the trace exposes branch sense, jump targets and the no-op path at once. Wrong ALU, load extraction or writeback state is latched into the register file without any later effect on the PC. That state is read out through the debug port once the program reaches its halt loop. Wrong store lanes appear on `dmem_be` and `dmem_wdata` in the same cycle as the store, and later as wrong bytes in the modelled memory.

// File: rtl/sc_core_pkg.sv
// Shared encodings and control bundle for the single-cycle integer core.
// Assumes a 32-bit data path and the standard base-integer opcode map.
package sc_core_pkg;

    localparam int XLEN = 32;

    localparam logic [6:0] OPC_OP     = 7'h33;
    localparam logic [6:0] OPC_OPIMM  = 7'h13;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_STORE  = 7'h23;
    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_LUI    = 7'h37;
    localparam logic [6:0] OPC_AUIPC  = 7'h17;
    localparam logic [6:0] OPC_JAL    = 7'h6F;
    localparam logic [6:0] OPC_JALR   = 7'h67;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_SLTU
    } alu_op_e;

    typedef enum logic [1:0] {SRCA_RS1, SRCA_PC, SRCA_ZERO} srca_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK}      wb_e;
    typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD}    size_e;

    typedef struct packed {
        alu_op_e           alu_op;
        srca_e             srca;
        logic              srcb_imm;
        logic              reg_we;
        wb_e               wb;
        logic              mem_rd;
        logic              mem_wr;
        size_e             size;
        logic              branch;
        logic [2:0]        cond;
        logic              jump;
        logic              jump_reg;
        logic [XLEN-1:0]   imm;
        logic              legal;
    } ctrl_t;

endpackage

// File: rtl/sc_core_decode.sv
// Instruction decoder: turns one 32-bit instruction word into a control bundle.
// Assumes the reduced integer subset; every unsupported encoding comes out
// with legal=0 and all side-effect enables cleared.
module sc_core_decode
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign f7  = instr[31:25];

    // Immediate formats, each sign-extended from instruction bit 31.
    assign imm_i = {{20{instr[31]}}, instr[31:20]};
    assign imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
    assign imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    assign imm_u = {instr[31:12], 12'b0};
    assign imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

    // Map a funct3 value (plus the alternate bit) to an ALU operation.
    function automatic alu_op_e f3_to_op(input logic [2:0] fn, input logic alt);
        case (fn)
            3'd0:    f3_to_op = alt ? ALU_SUB : ALU_ADD;
            3'd1:    f3_to_op = ALU_SLL;
            3'd2:    f3_to_op = ALU_SLT;
            3'd3:    f3_to_op = ALU_SLTU;
            3'd4:    f3_to_op = ALU_XOR;
            3'd5:    f3_to_op = alt ? ALU_SRA : ALU_SRL;
            3'd6:    f3_to_op = ALU_OR;
            default: f3_to_op = ALU_AND;
        endcase
    endfunction

    // Produce the control bundle, then strip side effects of illegal encodings.
    always_comb begin
        ctrl          = '0;
        ctrl.alu_op   = ALU_ADD;
        ctrl.srca     = SRCA_RS1;
        ctrl.wb       = WB_ALU;
        ctrl.size     = SZ_WORD;
        ctrl.cond     = f3;
        case (opc)
            OPC_OP: begin
                ctrl.legal  = (f7 == 7'h00) || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5));
                ctrl.alu_op = f3_to_op(f3, f7[5]);
                ctrl.reg_we = 1'b1;
            end
            OPC_OPIMM: begin
                ctrl.legal    = (f3 != 3'd1) && (f3 != 3'd5);
                ctrl.alu_op   = f3_to_op(f3, 1'b0);
                ctrl.srcb_imm = 1'b1;
                ctrl.imm      = imm_i;
                ctrl.reg_we   = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.legal    = (f3 <= 3'd2);
                ctrl.srcb_imm = 1'b1;
                ctrl.imm      = imm_i;
                ctrl.reg_we   = 1'b1;
                ctrl.mem_rd   = 1'b1;
                ctrl.wb       = WB_MEM;
                ctrl.size     = size_e'(f3[1:0]);
            end
            OPC_STORE: begin
                ctrl.legal    = (f3 <= 3'd2);
                ctrl.srcb_imm = 1'b1;
                ctrl.imm      = imm_s;
                ctrl.mem_wr   = 1'b1;
                ctrl.size     = size_e'(f3[1:0]);
            end
            OPC_BRANCH: begin
                ctrl.legal  = (f3 != 3'd2) && (f3 != 3'd3);
                ctrl.branch = 1'b1;
                ctrl.imm    = imm_b;
            end
            OPC_LUI: begin
                ctrl.legal    = 1'b1;
                ctrl.srca     = SRCA_ZERO;
                ctrl.srcb_imm = 1'b1;
                ctrl.imm      = imm_u;
                ctrl.reg_we   = 1'b1;
            end
            OPC_AUIPC: begin
                ctrl.legal    = 1'b1;
                ctrl.srca     = SRCA_PC;
                ctrl.srcb_imm = 1'b1;
                ctrl.imm      = imm_u;
                ctrl.reg_we   = 1'b1;
            end
            OPC_JAL: begin
                ctrl.legal  = 1'b1;
                ctrl.jump   = 1'b1;
                ctrl.imm    = imm_j;
                ctrl.reg_we = 1'b1;
                ctrl.wb     = WB_LINK;
            end
            OPC_JALR: begin
                ctrl.legal    = (f3 == 3'd0);
                ctrl.jump_reg = 1'b1;
                ctrl.srcb_imm = 1'b1;
                ctrl.imm      = imm_i;
                ctrl.reg_we   = 1'b1;
                ctrl.wb       = WB_LINK;
            end
            default: ctrl.legal = 1'b0;
        endcase
        if (!ctrl.legal) begin
            ctrl.reg_we   = 1'b0;
            ctrl.mem_rd   = 1'b0;
            ctrl.mem_wr   = 1'b0;
            ctrl.branch   = 1'b0;
            ctrl.jump     = 1'b0;
            ctrl.jump_reg = 1'b0;
        end
    end

endmodule

// File: rtl/sc_core_alu.sv
// Integer ALU plus the three comparison flags used by branches.
// Assumes W is a power of two so the shift amount is log2(W) bits.
module sc_core_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         eq,
    output logic         lt,
    output logic         ltu
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] shamt;

    assign shamt = b[SHW-1:0];
    assign eq    = (a == b);
    assign lt    = ($signed(a) < $signed(b));
    assign ltu   = (a < b);

    // Select the arithmetic, logic or shift result.
    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLL:  y = a << shamt;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = $unsigned($signed(a) >>> shamt);
            ALU_SLT:  y = {{(W-1){1'b0}}, lt};
            default:  y = {{(W-1){1'b0}}, ltu};
        endcase
    end

endmodule

// File: rtl/sc_core_regfile.sv
// Register file with two operand read ports, one debug read port and one write port.
// Entry 0 is hard zero; reset is synchronous and active low and clears all entries.
module sc_core_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    input  logic [$clog2(NREG)-1:0] rad,
    output logic [W-1:0]            rd1,
    output logic [W-1:0]            rd2,
    output logic [W-1:0]            rdd,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd
);

    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    // Clear every entry on reset; otherwise write any entry but zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != AW'(0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];
    assign rdd = (rad == AW'(0)) ? '0 : regs[rad];

    assert_x0_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);

endmodule

// File: rtl/sc_core_lsu.sv
// Load/store alignment: lane enables and replication for stores, lane
// selection and sign extension for loads. Assumes naturally aligned accesses.
module sc_core_lsu
    import sc_core_pkg::*;
#(
    parameter int DAW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  size_e             size,
    input  logic [DAW+1:0]    addr_lo,
    input  logic [XLEN-1:0]   st_data,
    output logic [DAW-1:0]    dmem_addr,
    output logic              dmem_rd_en,
    output logic              dmem_wr_en,
    output logic [3:0]        dmem_be,
    output logic [XLEN-1:0]   dmem_wdata,
    input  logic [XLEN-1:0]   dmem_rdata,
    output logic [XLEN-1:0]   ld_data
);

    logic [1:0]      lane;
    logic [XLEN-1:0] shifted;

    assign lane       = addr_lo[1:0];
    assign dmem_addr  = addr_lo[DAW+1:2];
    assign dmem_rd_en = mem_rd;
    assign dmem_wr_en = mem_wr;

    // Pick byte enables and replicate store data across lanes.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                dmem_be    = 4'b0001 << lane;
                dmem_wdata = {4{st_data[7:0]}};
            end
            SZ_HALF: begin
                dmem_be    = lane[1] ? 4'b1100 : 4'b0011;
                dmem_wdata = {2{st_data[15:0]}};
            end
            default: begin
                dmem_be    = 4'b1111;
                dmem_wdata = st_data;
            end
        endcase
        if (!mem_wr) dmem_be = 4'b0000;
    end

    // Shift the addressed lane down and sign-extend it to the full width.
    always_comb begin
        shifted = dmem_rdata >> {lane, 3'b000};
        case (size)
            SZ_BYTE: ld_data = {{(XLEN-8){shifted[7]}}, shifted[7:0]};
            SZ_HALF: ld_data = {{(XLEN-16){shifted[15]}}, shifted[15:0]};
            default: ld_data = dmem_rdata;
        endcase
    end

    assert_store_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr_en |-> ($countones(dmem_be) == 1 || $countones(dmem_be) == 2
                        || $countones(dmem_be) == 4));

    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd_en && dmem_wr_en));

endmodule

// File: rtl/sc_core.sv
// Single-cycle integer core top: PC register, decode, register file, ALU and
// load/store unit, closed by one clock edge per instruction. Assumes both
// memories reply combinationally within the cycle; reset is synchronous, active low.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_rdata,
    output logic [DMEM_AW-1:0] dmem_addr,
    output logic               dmem_rd_en,
    output logic               dmem_wr_en,
    output logic [3:0]         dmem_be,
    output logic [31:0]        dmem_wdata,
    input  logic [31:0]        dmem_rdata,
    output logic [31:0]        pc_o,
    input  logic [4:0]         dbg_raddr,
    output logic [31:0]        dbg_rdata
);

    localparam int NREG = 32;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jr_target;
    logic [XLEN-1:0] rs1_d, rs2_d, op_a, op_b, alu_y, ld_v, wb_v;
    logic            eq, lt, ltu, take;
    ctrl_t           ctl;

    assign imem_addr = pc_q[IMEM_AW+1:2];
    assign pc_o      = pc_q;

    sc_core_decode u_dec (
        .instr (imem_rdata),
        .ctrl  (ctl)
    );

    sc_core_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (imem_rdata[19:15]),
        .ra2   (imem_rdata[24:20]),
        .rad   (dbg_raddr),
        .rd1   (rs1_d),
        .rd2   (rs2_d),
        .rdd   (dbg_rdata),
        .we    (ctl.reg_we),
        .wa    (imem_rdata[11:7]),
        .wd    (wb_v)
    );

    // Choose the ALU's first operand.
    always_comb begin
        case (ctl.srca)
            SRCA_PC:   op_a = pc_q;
            SRCA_ZERO: op_a = '0;
            default:   op_a = rs1_d;
        endcase
    end

    assign op_b = ctl.srcb_imm ? ctl.imm : rs2_d;

    sc_core_alu #(.W(XLEN)) u_alu (
        .a   (op_a),
        .b   (op_b),
        .op  (ctl.alu_op),
        .y   (alu_y),
        .eq  (eq),
        .lt  (lt),
        .ltu (ltu)
    );

    sc_core_lsu #(.DAW(DMEM_AW)) u_lsu (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rd     (ctl.mem_rd),
        .mem_wr     (ctl.mem_wr),
        .size       (ctl.size),
        .addr_lo    (alu_y[DMEM_AW+1:0]),
        .st_data    (rs2_d),
        .dmem_addr  (dmem_addr),
        .dmem_rd_en (dmem_rd_en),
        .dmem_wr_en (dmem_wr_en),
        .dmem_be    (dmem_be),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .ld_data    (ld_v)
    );

    // Evaluate the branch condition from funct3.
    always_comb begin
        case (ctl.cond)
            3'd0:    take = eq;
            3'd1:    take = !eq;
            3'd4:    take = lt;
            3'd5:    take = !lt;
            3'd6:    take = ltu;
            default: take = !ltu;
        endcase
    end

    assign pc_plus4  = pc_q + STEP;
    assign br_target = pc_q + ctl.imm;
    assign jr_target = {alu_y[XLEN-1:1], 1'b0};

    // Select the next PC among sequential, relative target and register target.
    always_comb begin
        if (ctl.jump_reg)
            pc_next = jr_target;
        else if (ctl.jump || (ctl.branch && take))
            pc_next = br_target;
        else
            pc_next = pc_plus4;
    end

    // Select the value written back to rd.
    always_comb begin
        case (ctl.wb)
            WB_MEM:  wb_v = ld_v;
            WB_LINK: wb_v = pc_plus4;
            default: wb_v = alu_y;
        endcase
    end

    // Hold the program counter; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.legal |-> (!dmem_wr_en && !dmem_rd_en && !ctl.reg_we));

    assert_nop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.legal |=> (pc_q == $past(pc_q) + STEP));

    assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.jump && !ctl.jump_reg && !(ctl.branch && take)) |=> (pc_q == $past(pc_q) + STEP));

    assert_jalr_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump_reg |=> (pc_q[0] == 1'b0));

endmodule

// File: tb/sc_core_tb.sv
// Scoreboard bench: the driver loads a program and queues expected PCs and
// register values; the monitor pops and compares them against the ports.
module sc_core_tb;

    localparam logic [6:0] OP = 7'h33, OPI = 7'h13, LD = 7'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr, dmem_addr;
    logic [31:0] imem_rdata, dmem_rdata, dmem_wdata, pc_o, dbg_rdata;
    logic        dmem_rd_en, dmem_wr_en;
    logic [3:0]  dmem_be;
    logic [4:0]  dbg_raddr = 5'd0;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
    bit done = 1'b0;

    logic [31:0] q_pc[$];
    string       q_pct[$];
    int          q_reg[$];
    logic [31:0] q_val[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    sc_core u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_rd_en(dmem_rd_en), .dmem_wr_en(dmem_wr_en),
        .dmem_be(dmem_be), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .pc_o(pc_o), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
    );

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    // Byte-lane data memory model.
    always @(posedge clk) begin
        if (dmem_wr_en) begin
            for (int k = 0; k < 4; k++)
                if (dmem_be[k]) dmem[dmem_addr][8*k +: 8] <= dmem_wdata[8*k +: 8];
        end
    end

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3, logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, OP};
    endfunction
    function automatic logic [31:0] enc_i(logic [31:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                          logic [4:0] rd, logic [6:0] opc);
        return {imm[11:0], rs1, f3, rd, opc};
    endfunction
    function automatic logic [31:0] enc_s(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] enc_b(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'h63};
    endfunction
    function automatic logic [31:0] enc_j(logic [31:0] imm, logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6F};
    endfunction

    task automatic put(int addr, logic [31:0] w);
        imem[addr >> 2] = w;
    endtask
    task automatic exp_pc(logic [31:0] v, string t);
        q_pc.push_back(v); q_pct.push_back(t);
    endtask
    task automatic exp_reg(int r, logic [31:0] v, string t);
        q_reg.push_back(r); q_val.push_back(v); q_tag.push_back(t);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: program image, expected PC trace, expected registers, reset.
    initial begin
        put(0,   enc_i(5, 0, 0, 1, OPI));
        put(4,   enc_i(-3, 0, 0, 2, OPI));
        put(8,   enc_r(7'h00, 2, 1, 0, 3));
        put(12,  enc_r(7'h20, 2, 1, 0, 4));
        put(16,  enc_r(7'h00, 2, 1, 7, 5));
        put(20,  enc_r(7'h00, 2, 1, 6, 6));
        put(24,  enc_r(7'h00, 2, 1, 4, 7));
        put(28,  enc_r(7'h00, 1, 1, 1, 8));
        put(32,  enc_r(7'h00, 1, 2, 5, 9));
        put(36,  enc_r(7'h20, 1, 2, 5, 10));
        put(40,  enc_r(7'h00, 1, 2, 2, 11));
        put(44,  enc_r(7'h00, 1, 2, 3, 12));
        put(48,  enc_i(6, 1, 2, 13, OPI));
        put(52,  enc_i(-1, 1, 3, 14, OPI));
        put(56,  enc_i(32'hF0, 2, 7, 15, OPI));
        put(60,  enc_i(32'h100, 1, 6, 16, OPI));
        put(64,  enc_i(-1, 1, 4, 17, OPI));
        put(68,  {20'h12345, 5'd18, 7'h37});
        put(72,  {20'h00001, 5'd19, 7'h17});
        put(76,  enc_i(7, 1, 0, 0, OPI));
        put(80,  enc_s(0, 18, 0, 2));
        put(84,  enc_i(32'h100, 0, 0, 20, OPI));
        put(88,  enc_s(0, 7, 20, 2));
        put(92,  enc_s(1, 1, 20, 0));
        put(96,  enc_s(2, 16, 20, 1));
        put(100, enc_i(0, 20, 2, 21, LD));
        put(104, enc_i(0, 20, 0, 22, LD));
        put(108, enc_i(2, 20, 0, 23, LD));
        put(112, enc_i(2, 20, 1, 24, LD));
        put(116, enc_s(4, 2, 20, 2));
        put(120, enc_i(4, 20, 1, 25, LD));
        put(124, enc_i(7, 20, 0, 26, LD));
        put(128, enc_b(8, 1, 1, 0));
        put(132, enc_i(1, 0, 0, 27, OPI));
        put(136, enc_b(8, 1, 1, 1));
        put(140, enc_i(2, 27, 0, 27, OPI));
        put(144, enc_b(8, 1, 2, 4));
        put(148, enc_i(16, 27, 0, 27, OPI));
        put(152, enc_b(8, 1, 2, 5));
        put(156, enc_b(8, 1, 2, 6));
        put(160, enc_b(8, 1, 2, 7));
        put(164, enc_i(32, 27, 0, 27, OPI));
        put(168, enc_i(4, 27, 0, 27, OPI));
        put(172, 32'hFFFF_FFFF);
        put(176, enc_j(12, 28));
        put(180, enc_i(64, 27, 0, 27, OPI));
        put(184, enc_i(64, 27, 0, 27, OPI));
        put(188, enc_i(201, 0, 0, 29, OPI));
        put(192, enc_i(0, 29, 0, 30, 7'h67));
        put(196, enc_i(128, 27, 0, 27, OPI));
        put(200, enc_b(8, 2, 1, 5));
        put(204, enc_i(256, 27, 0, 27, OPI));
        put(208, enc_j(0, 0));

        for (int a = 0; a <= 128; a += 4) exp_pc(a, "R11 sequential pc");
        exp_pc(136, "R7 beq taken");
        exp_pc(140, "R7 bne not taken");
        exp_pc(144, "R7 step");
        exp_pc(152, "R7 blt taken");
        exp_pc(156, "R7 bge not taken");
        exp_pc(160, "R7 bltu not taken");
        exp_pc(168, "R7 bgeu taken");
        exp_pc(172, "R11 step");
        exp_pc(176, "R10 no-op advances");
        exp_pc(188, "R8 jal target");
        exp_pc(192, "R11 step");
        exp_pc(200, "R8 jalr bit0 cleared");
        exp_pc(208, "R7 bge taken");
        exp_pc(208, "R8 jal self loop");
        exp_pc(208, "R8 jal self loop");

        exp_reg(0,  32'h0,          "R9 x0 write discarded");
        exp_reg(1,  32'd5,          "R3 addi");
        exp_reg(2,  32'hFFFF_FFFD,  "R3 addi negative");
        exp_reg(3,  32'd2,          "R2 add");
        exp_reg(4,  32'd8,          "R2 sub");
        exp_reg(5,  32'd5,          "R2 and");
        exp_reg(6,  32'hFFFF_FFFD,  "R2 or");
        exp_reg(7,  32'hFFFF_FFF8,  "R2 xor");
        exp_reg(8,  32'd160,        "R2 sll");
        exp_reg(9,  32'h07FF_FFFF,  "R2 srl");
        exp_reg(10, 32'hFFFF_FFFF,  "R2 sra");
        exp_reg(11, 32'd1,          "R2 slt");
        exp_reg(12, 32'd0,          "R2 sltu");
        exp_reg(13, 32'd1,          "R3 slti");
        exp_reg(14, 32'd1,          "R3 sltiu");
        exp_reg(15, 32'h0000_00F0,  "R3 andi");
        exp_reg(16, 32'h0000_0105,  "R3 ori");
        exp_reg(17, 32'hFFFF_FFFA,  "R3 xori");
        exp_reg(18, 32'h1234_5000,  "R4 lui");
        exp_reg(19, 32'h0000_1048,  "R4 auipc");
        exp_reg(20, 32'h0000_0100,  "R3 base");
        exp_reg(21, 32'h0105_05F8,  "R5 lw merged lanes");
        exp_reg(22, 32'hFFFF_FFF8,  "R5 lb lane0 negative");
        exp_reg(23, 32'd5,          "R5 lb lane2 positive");
        exp_reg(24, 32'h0000_0105,  "R5 lh upper half");
        exp_reg(25, 32'hFFFF_FFFD,  "R5 lh lower half negative");
        exp_reg(26, 32'hFFFF_FFFF,  "R5 lb lane3");
        exp_reg(27, 32'd6,          "R7 branch path sum");
        exp_reg(28, 32'd180,        "R8 jal link");
        exp_reg(29, 32'd201,        "R3 odd target");
        exp_reg(30, 32'd196,        "R8 jalr link");
        exp_reg(31, 32'h0,          "R10 no-op no reg write");

        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    end

    // Monitor: reset state, per-cycle PC trace, store lanes, then register drain.
    initial begin
        logic [31:0] e;
        string t;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset pc", pc_o, 32'h0);
        dbg_raddr = 5'd7;  #1; chk("R1 reset x7", dbg_rdata, 32'h0);
        dbg_raddr = 5'd31; #1; chk("R1 reset x31", dbg_rdata, 32'h0);
        wait (rst_n === 1'b1);
        #1;
        while (q_pc.size() > 0) begin
            e = q_pc.pop_front();
            t = q_pct.pop_front();
            chk(t, pc_o, e);
            if (dmem_rd_en === 1'b1) n_rd++;
            if (dmem_wr_en === 1'b1) n_wr++;
            if (pc_o == 32'd92) begin
                chk("R6 sb lanes", {28'h0, dmem_be}, 32'h2);
                chk("R6 sb data", dmem_wdata, 32'h0505_0505);
            end
            if (pc_o == 32'd96) begin
                chk("R6 sh lanes", {28'h0, dmem_be}, 32'hC);
                chk("R6 sh data", dmem_wdata, 32'h0105_0105);
            end
            if (pc_o == 32'd172)
                chk("R10 no-op mem quiet", {30'h0, dmem_rd_en, dmem_wr_en}, 32'h0);
            @(negedge clk);
            #1;
        end
        chk("R5 load count", n_rd, 6);
        chk("R6 store count", n_wr, 5);
        chk("R6 sw word", dmem[0], 32'h1234_5000);
        chk("R6 merged word", dmem[64], 32'h0105_05F8);
        chk("R6 second word", dmem[65], 32'hFFFF_FFFD);
        while (q_reg.size() > 0) begin
            dbg_raddr = 5'(q_reg.pop_front());
            e = q_val.pop_front();
            t = q_tag.pop_front();
            #1;
            chk(t, dbg_rdata, e);
        end
        done = 1'b1;
    end

    // Watchdog and final summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule